// File: doc/BRIEF.md
# Power-Mode and Startup Sequencer

This block is a synchronous controller for a contactless reader's power and startup modes. It holds the chip in a power-down phase while a power-on-reset flag is active, or while an external power-down pin has stayed high for a qualifying time. It then runs a reset phase, which counts only while the oscillator reports itself stable. An initialising phase follows, and after it a ready phase. During the reset phase a preset strobe tells the register file to load its preset values.

Once the block is ready, software can put it into standby. Standby removes the internal digital clock enable but leaves the oscillator alone. Writing the standby bit back to zero starts a short exit sequence, and the bit keeps reading as one until that sequence has finished. A second control bit makes the receiver supply follow a receiver-in-use input instead of staying on all the time.

Top module: `pwr_seq_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `phase_o` is 0, `preset_o` is 0, `clk_en_o` is 1, `rx_pwr_o` is 0 and `stby_rd_o` is 0. The `phase_o` codes are: 0 power-down, 1 reset, 2 initialising, 3 ready, 4 standby.
- R2: While `por_i` is high, `phase_o` stays 0.
- R3: `pd_pin_i` takes effect only after it has been sampled high on PD_MIN_CYC consecutive clock edges (default 1356). One edge after that, `phase_o` becomes 0. A high run that is one edge shorter has no effect.
- R4: Power-down is always followed by the reset phase (code 1). That phase counts only on edges where `osc_ok_i` is high. `preset_o` is high for exactly RST_CYC (512) cycles per complete reset phase, and it is high only in the cycle after a reset-phase edge.
- R5: The initialising phase (code 2) lasts INIT_CYC (64) cycles and is followed by ready (code 3).
- R6: In ready, a write with `stby_wdata_i`=1 makes `phase_o` 4, `clk_en_o` 0 and `stby_rd_o` 1 on the next edge.
- R7: In standby, a write with `stby_wdata_i`=0 keeps `phase_o` at 4 and `stby_rd_o` at 1 for EXIT_CYC (4) more edges. On the following edge the block returns to ready with `stby_rd_o` 0 and `clk_en_o` 1.
- R8: A write to the standby bit in any phase other than ready does not make the block enter standby.
- R9: `rx_pwr_o` is 1 only in the cycle after a ready-phase edge. With the auto-power-down bit at 0 it is then always 1. With the bit at 1 it follows `rx_busy_i` with one cycle of delay.
- R10: An active `por_i`, or a qualified pin event, sends the block to power-down on the next edge from every phase, including reset, initialising and standby.
- R11: Writes to the auto-power-down bit count only in ready. The preset strobe clears the bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_i | input | 1 | Power-on-reset flag |
| pd_pin_i | input | 1 | Synchronised external power-down pin, active high |
| osc_ok_i | input | 1 | Oscillator stable |
| stby_wr_i | input | 1 | Write strobe for the standby bit |
| stby_wdata_i | input | 1 | Value written to the standby bit |
| rxapd_wr_i | input | 1 | Write strobe for the receiver auto-power-down bit |
| rxapd_wdata_i | input | 1 | Value written to the auto-power-down bit |
| rx_busy_i | input | 1 | Receiver in use |
| phase_o | output | 3 | Current phase code |
| preset_o | output | 1 | Register preset strobe |
| clk_en_o | output | 1 | Internal digital clock enable |
| rx_pwr_o | output | 1 | Receiver power enable |
| stby_rd_o | output | 1 | Standby bit readback |

## Verification
The assertions assume that every input is already synchronous to `clk` and stays stable across each sampling edge. They also assume that `por_i` and `pd_pin_i` are plain levels and not glitches inside a cycle. The bench changes inputs only on falling edges and raises each write strobe for one cycle at a time. It runs pin pulses both exactly one edge short of qualification and well past it. It also toggles `osc_ok_i` and writes both control bits in phases where the writes must be ignored. The reference model assumes nothing about which phase a write or reset event arrives in. It applies the same priority order to every cycle: reset events first, then phase stepping, then writes.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    PH_OFF    = 3'd0,
    PH_PRESET = 3'd1,
    PH_INIT   = 3'd2,
    PH_RUN    = 3'd3,
    PH_SLEEP  = 3'd4
  } phase_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pwr_pin_qual.sv
// Qualifies the power-down pin: it counts consecutive high samples and
// saturates at the minimum width.
module pwr_pin_qual #(
  parameter int unsigned MIN_CYC = 1356
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic qual_o
);
  localparam int unsigned CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(MIN_CYC);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (!pin_i) begin
      run_q <= '0;
    end else if (run_q != LIM) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign qual_o = (run_q == LIM);

endmodule

// File: rtl/pwr_phase_fsm.sv
// Phase sequencer: power-down, reset, initialising, ready and standby.
module pwr_phase_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned RST_CYC  = 512,
  parameter int unsigned INIT_CYC = 64,
  parameter int unsigned EXIT_CYC = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   hold_i,
  input  logic   osc_ok_i,
  input  logic   stby_wr_i,
  input  logic   stby_val_i,
  output phase_e phase_o,
  output logic   preset_now_o,
  output logic   ready_o,
  output logic   clk_en_o,
  output logic   stby_rd_o
);
  localparam int unsigned CMAX = max3(RST_CYC, INIT_CYC, EXIT_CYC);
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] RST_LAST  = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] INIT_LAST = CW'(INIT_CYC - 1);
  localparam logic [CW-1:0] EXIT_LAST = CW'(EXIT_CYC - 1);

  phase_e        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          exit_q, exit_d;
  logic          clk_en_q, stby_q;

  always_comb begin
    st_d         = st_q;
    cnt_d        = cnt_q;
    exit_d       = exit_q;
    preset_now_o = 1'b0;
    if (hold_i) begin
      st_d   = PH_OFF;
      cnt_d  = '0;
      exit_d = 1'b0;
    end else begin
      case (st_q)
        PH_OFF: begin
          st_d  = PH_PRESET;
          cnt_d = '0;
        end
        PH_PRESET: begin
          if (osc_ok_i) begin
            preset_now_o = 1'b1;
            if (cnt_q == RST_LAST) begin
              st_d  = PH_INIT;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        PH_INIT: begin
          if (cnt_q == INIT_LAST) begin
            st_d  = PH_RUN;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_RUN: begin
          if (stby_wr_i && stby_val_i) begin
            st_d   = PH_SLEEP;
            cnt_d  = '0;
            exit_d = 1'b0;
          end
        end
        PH_SLEEP: begin
          if (exit_q) begin
            if (cnt_q == EXIT_LAST) begin
              st_d   = PH_RUN;
              cnt_d  = '0;
              exit_d = 1'b0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else if (stby_wr_i && !stby_val_i) begin
            exit_d = 1'b1;
            cnt_d  = '0;
          end
        end
        default: begin
          st_d  = PH_OFF;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= PH_OFF;
      cnt_q    <= '0;
      exit_q   <= 1'b0;
      clk_en_q <= 1'b1;
      stby_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      exit_q   <= exit_d;
      clk_en_q <= (st_d != PH_SLEEP);
      stby_q   <= (st_d == PH_SLEEP);
    end
  end

  assign phase_o   = st_q;
  assign ready_o   = (st_q == PH_RUN);
  assign clk_en_o  = clk_en_q;
  assign stby_rd_o = stby_q;

endmodule

// File: rtl/pwr_rx_ctl.sv
// Holds the receiver auto-power-down bit and drives the receiver supply enable.
module pwr_rx_ctl (
  input  logic clk,
  input  logic rst,
  input  logic preset_i,
  input  logic ready_i,
  input  logic wr_i,
  input  logic val_i,
  input  logic busy_i,
  output logic rx_pwr_o
);
  logic apd_q;
  logic pwr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      apd_q <= 1'b0;
      pwr_q <= 1'b0;
    end else begin
      if (preset_i) begin
        apd_q <= 1'b0;
      end else if (ready_i && wr_i) begin
        apd_q <= val_i;
      end
      pwr_q <= ready_i && (!apd_q || busy_i);
    end
  end

  assign rx_pwr_o = pwr_q;

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int unsigned PD_MIN_CYC = 1356,
  parameter int unsigned RST_CYC    = 512,
  parameter int unsigned INIT_CYC   = 64,
  parameter int unsigned EXIT_CYC   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       por_i,
  input  logic       pd_pin_i,
  input  logic       osc_ok_i,
  input  logic       stby_wr_i,
  input  logic       stby_wdata_i,
  input  logic       rxapd_wr_i,
  input  logic       rxapd_wdata_i,
  input  logic       rx_busy_i,
  output logic [2:0] phase_o,
  output logic       preset_o,
  output logic       clk_en_o,
  output logic       rx_pwr_o,
  output logic       stby_rd_o
);
  logic   pin_qual;
  logic   hold;
  logic   preset_now;
  logic   ready;
  logic   preset_q;
  phase_e phase;

  pwr_pin_qual #(.MIN_CYC(PD_MIN_CYC)) pin_qual_i (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pd_pin_i),
    .qual_o (pin_qual)
  );

  assign hold = por_i | pin_qual;

  pwr_phase_fsm #(
    .RST_CYC  (RST_CYC),
    .INIT_CYC (INIT_CYC),
    .EXIT_CYC (EXIT_CYC)
  ) fsm_i (
    .clk          (clk),
    .rst          (rst),
    .hold_i       (hold),
    .osc_ok_i     (osc_ok_i),
    .stby_wr_i    (stby_wr_i),
    .stby_val_i   (stby_wdata_i),
    .phase_o      (phase),
    .preset_now_o (preset_now),
    .ready_o      (ready),
    .clk_en_o     (clk_en_o),
    .stby_rd_o    (stby_rd_o)
  );

  pwr_rx_ctl rx_i (
    .clk      (clk),
    .rst      (rst),
    .preset_i (preset_now),
    .ready_i  (ready),
    .wr_i     (rxapd_wr_i),
    .val_i    (rxapd_wdata_i),
    .busy_i   (rx_busy_i),
    .rx_pwr_o (rx_pwr_o)
  );

  always_ff @(posedge clk) begin
    if (rst) preset_q <= 1'b0;
    else     preset_q <= preset_now;
  end

  assign preset_o = preset_q;
  assign phase_o  = phase;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       por_i,
  input logic [2:0] phase_o,
  input logic       preset_o,
  input logic       clk_en_o,
  input logic       rx_pwr_o,
  input logic       stby_rd_o
);
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    phase_o <= 3'd4); // R1

  AST_POR_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
    por_i |=> (phase_o == 3'd0)); // R10

  AST_PRESET_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    preset_o |-> ($past(phase_o) == 3'd1)); // R4

  AST_SLEEP_GATES_CLK: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 3'd4) |-> (!clk_en_o && stby_rd_o)); // R6

  AST_SLEEP_FROM_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_o == 3'd4) |-> ($past(phase_o) == 3'd3)); // R8

  AST_WAKE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $fell(stby_rd_o) |-> (phase_o == 3'd3 || phase_o == 3'd0)); // R7

  AST_RX_OFF_OUTSIDE_READY: assert property (@(posedge clk) disable iff (rst)
    (phase_o != 3'd3) |=> !rx_pwr_o); // R9
endmodule

bind pwr_seq_top pwr_seq_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .por_i     (por_i),
  .phase_o   (phase_o),
  .preset_o  (preset_o),
  .clk_en_o  (clk_en_o),
  .rx_pwr_o  (rx_pwr_o),
  .stby_rd_o (stby_rd_o)
);

// File: tb/pwr_seq_top_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_top_tb_top;
  localparam int PDMIN = 1356;
  localparam int RSTN  = 512;
  localparam int INITN = 64;
  localparam int EXITN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por = 1'b0, pd = 1'b0, osc = 1'b0;
  logic swr = 1'b0, sdat = 1'b0, awr = 1'b0, adat = 1'b0, busy = 1'b0;
  logic [2:0] phase;
  logic preset, clk_en, rx_pwr, stby_rd;

  always #2.5 clk = ~clk;

  pwr_seq_top dut_i (
    .clk(clk), .rst(rst), .por_i(por), .pd_pin_i(pd), .osc_ok_i(osc),
    .stby_wr_i(swr), .stby_wdata_i(sdat), .rxapd_wr_i(awr),
    .rxapd_wdata_i(adat), .rx_busy_i(busy),
    .phase_o(phase), .preset_o(preset), .clk_en_o(clk_en),
    .rx_pwr_o(rx_pwr), .stby_rd_o(stby_rd)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit started = 0;

  // behavioural reference model
  int m_ph = 0, m_run = 0, m_cnt = 0;
  bit m_exit = 0, m_apd = 0, m_rx = 0, m_pre = 0;

  always @(posedge clk) begin
    bit qual, hold, pre_n, rx_n;
    started = 1;
    if (rst) begin
      m_ph = 0; m_run = 0; m_cnt = 0; m_exit = 0;
      m_apd = 0; m_rx = 0; m_pre = 0;
    end else begin
      qual  = (m_run == PDMIN);
      hold  = por || qual;
      pre_n = !hold && m_ph == 1 && osc;
      rx_n  = (m_ph == 3) && (!m_apd || busy);
      if (pre_n) m_apd = 0;
      else if (m_ph == 3 && awr) m_apd = adat;
      if (hold) begin
        m_ph = 0; m_cnt = 0; m_exit = 0;
      end else if (m_ph == 0) begin
        m_ph = 1; m_cnt = 0;
      end else if (m_ph == 1) begin
        if (osc) begin
          m_cnt++;
          if (m_cnt == RSTN) begin m_ph = 2; m_cnt = 0; end
        end
      end else if (m_ph == 2) begin
        m_cnt++;
        if (m_cnt == INITN) begin m_ph = 3; m_cnt = 0; end
      end else if (m_ph == 3) begin
        if (swr && sdat) begin m_ph = 4; m_exit = 0; end
      end else begin
        if (m_exit) begin
          m_cnt++;
          if (m_cnt == EXITN) begin m_ph = 3; m_exit = 0; m_cnt = 0; end
        end else if (swr && !sdat) begin
          m_exit = 1; m_cnt = 0;
        end
      end
      m_run = pd ? ((m_run < PDMIN) ? m_run + 1 : m_run) : 0;
      m_pre = pre_n;
      m_rx  = rx_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(phase === 3'(m_ph), "R2/R3/R4/R5/R10 phase", int'(phase), m_ph);
      chk(preset === m_pre, "R4 preset", int'(preset), int'(m_pre));
      chk(clk_en === (m_ph != 4), "R6/R7 clk_en", int'(clk_en), int'(m_ph != 4));
      chk(stby_rd === (m_ph == 4), "R7 stby_rd", int'(stby_rd), int'(m_ph == 4));
      chk(rx_pwr === m_rx, "R9/R11 rx_pwr", int'(rx_pwr), int'(m_rx));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw(input bit v);
    swr = 1; sdat = v; cyc(1); swr = 0;
  endtask

  task automatic aw(input bit v);
    awr = 1; adat = v; cyc(1); awr = 0;
  endtask

  task automatic wait_ph(input int p);
    int g = 0;
    while (phase !== 3'(p) && g < 3000) begin cyc(1); g++; end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int pc, ic;
    cyc(3);
    // R1 reset state
    chk(phase === 3'd0 && preset === 0 && clk_en === 1 && rx_pwr === 0 && stby_rd === 0,
        "R1 reset outputs", int'(phase), 0);
    rst = 0; por = 1;
    cyc(10);
    chk(phase === 3'd0, "R2 por holds off", int'(phase), 0);
    por = 0;
    cyc(20);
    chk(phase === 3'd1 && preset === 0, "R4 waits for osc", int'(phase), 1);
    osc = 1;
    pc = 0;
    do begin cyc(1); if (preset === 1'b1) pc++; end while (phase !== 3'd2 && pc < 2000);
    chk(pc == RSTN, "R4 preset count", pc, RSTN);
    ic = 1;
    forever begin cyc(1); if (phase === 3'd2) ic++; else break; end
    chk(ic == INITN, "R5 init length", ic, INITN);
    chk(phase === 3'd3, "R5 ready", int'(phase), 3);
    cyc(2);
    chk(rx_pwr === 1, "R9 rx on with apd 0", int'(rx_pwr), 1);
    aw(1); busy = 0; cyc(3);
    chk(rx_pwr === 0, "R9 rx off idle", int'(rx_pwr), 0);
    busy = 1; cyc(1);
    chk(rx_pwr === 1, "R9 rx follows busy", int'(rx_pwr), 1);
    busy = 0;
    // standby entry and exit
    sw(1);
    chk(phase === 3'd4 && clk_en === 0 && stby_rd === 1, "R6 enter standby", int'(phase), 4);
    cyc(5);
    sw(1);
    chk(phase === 3'd4, "R7 second write", int'(phase), 4);
    sw(0);
    for (int i = 1; i < EXITN; i++) begin
      chk(stby_rd === 1 && phase === 3'd4, "R7 readback held", int'(stby_rd), 1);
      cyc(1);
    end
    chk(stby_rd === 1, "R7 last held cycle", int'(stby_rd), 1);
    cyc(1);
    chk(phase === 3'd3 && stby_rd === 0 && clk_en === 1, "R7 exit done", int'(phase), 3);
    // short pin pulse
    pd = 1; cyc(PDMIN - 1); pd = 0; cyc(3);
    chk(phase === 3'd3, "R3 short pulse ignored", int'(phase), 3);
    pd = 1; cyc(PDMIN + 1);
    chk(phase === 3'd0, "R3 qualified pin", int'(phase), 0);
    cyc(40);
    chk(phase === 3'd0, "R3 held while high", int'(phase), 0);
    pd = 0; cyc(5);
    chk(phase === 3'd1, "R4 reset follows", int'(phase), 1);
    sw(1);
    chk(phase === 3'd1 && stby_rd === 0, "R8 write ignored in reset", int'(phase), 1);
    aw(1);
    por = 1; cyc(1); por = 0;
    chk(phase === 3'd0, "R10 por in reset", int'(phase), 0);
    osc = 0; cyc(30);
    chk(phase === 3'd1 && preset === 0, "R4 paused without osc", int'(phase), 1);
    osc = 1;
    wait_ph(2);
    sw(1);
    chk(phase === 3'd2, "R8 write ignored in init", int'(phase), 2);
    aw(1);
    wait_ph(3); busy = 0; cyc(2);
    chk(rx_pwr === 1, "R11 apd cleared and init write ignored", int'(rx_pwr), 1);
    cyc(10);
    por = 1; cyc(1); por = 0;
    chk(phase === 3'd0, "R10 por in ready", int'(phase), 0);
    wait_ph(2); cyc(5);
    por = 1; cyc(1); por = 0;
    chk(phase === 3'd0, "R10 por in init", int'(phase), 0);
    wait_ph(3); cyc(2);
    sw(1); cyc(2);
    pd = 1; cyc(PDMIN + 1);
    chk(phase === 3'd0 && clk_en === 1, "R10 pin in standby", int'(phase), 0);
    pd = 0; cyc(5);
    finish_run();
  end
endmodule